// File: doc/BRIEF.md
# Opcode Fetch Bus Sequencer

This block runs the instruction-fetch machine cycle of a small 8-bit processor. The cycle has four clock states, T1 to T4. A fetch is requested through a valid/ready handshake that carries the program counter. The sequencer puts the program counter on the address bus and lowers the memory-request and read strobes half a clock later, so the address has settled before memory is enabled. It captures the opcode from the data bus on the rising edge that opens T3, and releases both strobes on that same edge.

T3 and T4 are then given to a dynamic-memory refresh. The refresh counter goes onto the low address bits, and memory request and the refresh strobe are pulsed between the falling edge inside T3 and the falling edge inside T4. The processor decodes the captured opcode during this time. No other bus operation takes place in these two states.

Handshake rules: a request is taken on a rising edge where `start_valid` and `start_ready` are both high. `start_ready` is high only when the sequencer is idle or in T4. A requester held off by back-pressure keeps `start_valid` and `start_pc` steady until it is accepted. The opcode output has no back-pressure: `fetch_valid` is a single-cycle pulse, and the consumer must take the opcode in that cycle.

Top module: `fetch_cycle_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer goes idle. `mreq_n`, `rd_n` and `rfsh_n` read 1, `fetch_valid` reads 0 and `start_ready` reads 1. The refresh counter loads `rfsh_seed`.
- R2: After the rising edge that accepts a request, `addr` equals the accepted `start_pc`. It holds that value through T1 and T2 even if `start_pc` changes after acceptance.
- R3: `mreq_n` and `rd_n` stay 1 during the first half of T1. Both go to 0 on the falling edge inside T1 and stay 0 through T2.
- R4: `opcode` takes the value on `data_in` at the rising edge that begins T3. Later changes of `data_in` leave `opcode` unchanged.
- R5: `rd_n` and `mreq_n` return to 1 on the rising edge that begins T3.
- R6: `fetch_valid` is 1 for exactly one cycle, during T3, three rising edges after the accepting edge.
- R7: During T3 and T4, `addr` equals the refresh counter, zero-extended. `rfsh_n` and `mreq_n` are 0 from the falling edge inside T3 to the falling edge inside T4. `rd_n` stays 1 throughout.
- R8: At the end of each fetch, the low 7 bits of the 8-bit refresh counter increment and wrap, and bit 7 keeps its value. For example, 0x7F becomes 0x00 and 0xFF becomes 0x80.
- R9: `start_ready` is 0 during T1, T2 and T3, and 1 in T4 and when idle. A request present in T4 is accepted on the edge that ends T4, and T1 of the next fetch follows at once.
- R10: `rfsh_n` and `rd_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| start_valid | input | 1 | Fetch request valid |
| start_ready | output | 1 | Sequencer can accept a request |
| start_pc | input | 16 | Program counter carried by the request |
| rfsh_seed | input | 8 | Refresh counter value loaded during reset |
| data_in | input | 8 | Data bus from memory |
| addr | output | 16 | Address bus |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| opcode | output | 8 | Captured opcode |
| fetch_valid | output | 1 | One-cycle pulse marking a new opcode |

## Verification
A wrong phase state appears at the ports within half a clock, because every strobe edge is derived from the phase. A phase that is skipped or repeated moves the `fetch_valid` pulse away from the third edge after acceptance, and it shifts the timing of `start_ready`. An error in the refresh counter does not show during the fetch where it happens. It appears on `addr` in the T3 of the following fetch, so the bench runs several fetches in sequence and checks seed values at both wrap points.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_t;
endpackage

// File: rtl/fetch_phase_fsm.sv
module fetch_phase_fsm
  import fetch_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  output logic   req_ready,
  output logic   accept,
  output phase_t phase
);
  phase_t phase_d;

  assign req_ready = (phase == PH_IDLE) || (phase == PH_T4);
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (accept) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_T4;
      PH_T4:   phase_d = accept ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_d;
  end
endmodule

// File: rtl/fetch_strobe_gen.sv
module fetch_strobe_gen
  import fetch_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  output logic   mreq_n,
  output logic   rd_n,
  output logic   rfsh_n
);
  logic read_win_q;
  logic rfsh_win_q;
  logic read_phase;
  logic read_act;

  assign read_phase = (phase == PH_T1) || (phase == PH_T2);

  // Half-cycle flops: they open windows on the falling edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      read_win_q <= 1'b0;
      rfsh_win_q <= 1'b0;
    end else begin
      read_win_q <= read_phase;
      rfsh_win_q <= (phase == PH_T3);
    end
  end

  // Read window closes on the rising edge that leaves T2.
  assign read_act = read_win_q && read_phase;

  assign rd_n   = ~read_act;
  assign rfsh_n = ~rfsh_win_q;
  assign mreq_n = ~(read_act || rfsh_win_q);
endmodule

// File: rtl/fetch_refresh_ctr.sv
module fetch_refresh_ctr #(
  parameter int RF_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RF_W-1:0] seed,
  input  logic            step,
  output logic [RF_W-1:0] count
);
  localparam int LOW_W = RF_W - 1;
  localparam logic [LOW_W-1:0] ONE = LOW_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       count <= seed;
    else if (step) count <= {count[RF_W-1], count[LOW_W-1:0] + ONE};
  end
endmodule

// File: rtl/fetch_bus_path.sv
module fetch_bus_path
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RF_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] pc,
  input  logic [RF_W-1:0]   rfsh_count,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] opcode,
  output logic              fetch_valid
);
  localparam int PAD_W = ADDR_W - RF_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr        <= '0;
      opcode      <= '0;
      fetch_valid <= 1'b0;
    end else begin
      fetch_valid <= (phase == PH_T2);
      if (phase == PH_T2) begin
        opcode <= data_in;
        addr   <= {{PAD_W{1'b0}}, rfsh_count};
      end else if (accept) begin
        addr <= pc;
      end
    end
  end
endmodule

// File: rtl/fetch_cycle_seq.sv
module fetch_cycle_seq
  import fetch_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RF_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [RF_W-1:0]   rfsh_seed,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              rfsh_n,
  output logic [DATA_W-1:0] opcode,
  output logic              fetch_valid
);
  phase_t          phase;
  logic            accept;
  logic [RF_W-1:0] rfsh_count;

  fetch_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(start_valid), .req_ready(start_ready),
    .accept(accept), .phase(phase)
  );

  fetch_strobe_gen u_strb (
    .clk(clk), .rst(rst), .phase(phase),
    .mreq_n(mreq_n), .rd_n(rd_n), .rfsh_n(rfsh_n)
  );

  fetch_refresh_ctr #(.RF_W(RF_W)) u_rctr (
    .clk(clk), .rst(rst), .seed(rfsh_seed),
    .step(phase == PH_T4), .count(rfsh_count)
  );

  fetch_bus_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RF_W(RF_W)) u_path (
    .clk(clk), .rst(rst), .accept(accept), .phase(phase), .pc(start_pc),
    .rfsh_count(rfsh_count), .data_in(data_in), .addr(addr),
    .opcode(opcode), .fetch_valid(fetch_valid)
  );
endmodule

// File: rtl/fetch_seq_checker.sv
module fetch_seq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_valid,
  input logic              start_ready,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_n,
  input logic              rfsh_n,
  input logic              fetch_valid
);
  logic taken;
  assign taken = start_valid && start_ready;

  p_strobe_window_r3: assert property (@(posedge clk) disable iff (rst)
    taken |=> !rd_n ##1 !rd_n ##1 rd_n);

  p_release_at_t3_r5: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> rd_n);

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);

  p_valid_timing_r6: assert property (@(posedge clk) disable iff (rst)
    taken |-> ##3 fetch_valid);

  p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    taken |=> !start_ready ##1 !start_ready ##1 !start_ready ##1 start_ready);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(!rd_n)) |-> $stable(addr));

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n |-> rd_n);
endmodule

bind fetch_cycle_seq fetch_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
  .addr(addr), .rd_n(rd_n), .rfsh_n(rfsh_n), .fetch_valid(fetch_valid)
);

// File: tb/sim_fetch_cycle_seq.sv
`timescale 1ns/100ps
module sim_fetch_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] start_pc = '0;
  logic [7:0]  rfsh_seed = '0;
  logic [7:0]  data_in = '0;
  logic [15:0] addr;
  logic        mreq_n, rd_n, rfsh_n, fetch_valid;
  logic [7:0]  opcode;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [7:0] exp_cnt;

  always #2.5 clk = ~clk;

  fetch_cycle_seq u0 (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .start_pc(start_pc), .rfsh_seed(rfsh_seed), .data_in(data_in), .addr(addr),
    .mreq_n(mreq_n), .rd_n(rd_n), .rfsh_n(rfsh_n), .opcode(opcode),
    .fetch_valid(fetch_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] bump(input logic [7:0] v);
    return {v[7], v[6:0] + 7'd1};
  endfunction

  task automatic t_reset(input logic [7:0] seed);
    rfsh_seed = seed;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 mreq_n", mreq_n, 1);
    check("R1 rd_n", rd_n, 1);
    check("R1 rfsh_n", rfsh_n, 1);
    check("R1 fetch_valid", fetch_valid, 0);
    check("R1 start_ready", start_ready, 1);
    rst = 1'b0;
    exp_cnt = seed;
    @(posedge clk); #1;
  endtask

  // Full fetch from idle, checking every half-cycle.
  task automatic t_fetch(input logic [15:0] pc, input logic [7:0] op);
    @(negedge clk); #1;
    start_valid = 1'b1; start_pc = pc; data_in = 8'h00;
    check("R9 ready idle", start_ready, 1);
    @(posedge clk); #1;                       // T1 first half
    start_valid = 1'b0; start_pc = ~pc;       // R2: must be ignored
    check("R2 addr T1", addr, pc);
    check("R3 mreq_n early T1", mreq_n, 1);
    check("R3 rd_n early T1", rd_n, 1);
    check("R9 ready T1", start_ready, 0);
    @(negedge clk); #1;                       // T1 second half
    check("R3 mreq_n mid T1", mreq_n, 0);
    check("R3 rd_n mid T1", rd_n, 0);
    check("R10 rfsh_n T1", rfsh_n, 1);
    @(posedge clk); #1;                       // T2
    check("R2 addr T2", addr, pc);
    check("R3 rd_n T2", rd_n, 0);
    check("R9 ready T2", start_ready, 0);
    data_in = op;
    @(posedge clk); #1;                       // T3 first half
    data_in = ~op;                            // R4: must be ignored
    check("R4 opcode", opcode, op);
    check("R6 fetch_valid T3", fetch_valid, 1);
    check("R5 rd_n T3", rd_n, 1);
    check("R5 mreq_n T3", mreq_n, 1);
    check("R7 addr refresh", addr, {8'h00, exp_cnt});
    check("R7 rfsh_n early T3", rfsh_n, 1);
    check("R9 ready T3", start_ready, 0);
    @(negedge clk); #1;                       // T3 second half
    check("R7 rfsh_n mid T3", rfsh_n, 0);
    check("R7 mreq_n mid T3", mreq_n, 0);
    check("R7 rd_n mid T3", rd_n, 1);
    @(posedge clk); #1;                       // T4 first half
    check("R6 fetch_valid T4", fetch_valid, 0);
    check("R4 opcode hold", opcode, op);
    check("R7 rfsh_n T4", rfsh_n, 0);
    check("R7 addr T4", addr, {8'h00, exp_cnt});
    check("R9 ready T4", start_ready, 1);
    @(negedge clk); #1;                       // T4 second half
    check("R7 rfsh_n end", rfsh_n, 1);
    check("R7 mreq_n end", mreq_n, 1);
    @(posedge clk); #1;                       // idle
    exp_cnt = bump(exp_cnt);
    check("R9 ready idle after", start_ready, 1);
    check("R6 fetch_valid idle", fetch_valid, 0);
  endtask

  // Request held while busy, accepted at end of T4.
  task automatic t_back_to_back(input logic [15:0] pc1, input logic [15:0] pc2);
    @(negedge clk); #1;
    start_valid = 1'b1; start_pc = pc1;
    @(posedge clk); #1;                       // T1
    start_pc = pc2;                           // held request for next fetch
    check("R9 held not taken T1", start_ready, 0);
    @(posedge clk); #1;                       // T2
    check("R2 addr pc1", addr, pc1);
    @(posedge clk); #1;                       // T3
    check("R9 held not taken T3", start_ready, 0);
    check("R7 addr refresh b2b", addr, {8'h00, exp_cnt});
    @(posedge clk); #1;                       // T4
    check("R9 ready T4 b2b", start_ready, 1);
    @(posedge clk); #1;                       // T1 of next fetch
    start_valid = 1'b0;
    exp_cnt = bump(exp_cnt);
    check("R9 b2b addr", addr, pc2);
    check("R9 b2b ready", start_ready, 0);
    check("R3 b2b rd_n early", rd_n, 1);
    @(negedge clk); #1;
    check("R3 b2b rd_n mid", rd_n, 0);
    repeat (2) @(posedge clk);
    #1;
    check("R6 b2b valid", fetch_valid, 1);
    check("R8 b2b refresh addr", addr, {8'h00, exp_cnt});
    repeat (2) @(posedge clk);
    #1;
    exp_cnt = bump(exp_cnt);
  endtask

  initial begin
    t_reset(8'h05);
    t_fetch(16'h1234, 8'h3C);
    t_fetch(16'hFFFF, 8'hA5);                 // R8: counter now seed+2
    t_back_to_back(16'h0100, 16'h0101);
    t_fetch(16'h0000, 8'hFF);
    t_reset(8'h7F);                           // R8 wrap, top bit 0
    t_fetch(16'h4000, 8'h01);
    t_fetch(16'h4001, 8'h80);                 // expects refresh 0x00
    t_reset(8'hFF);                           // R8 wrap, top bit 1
    t_fetch(16'h8000, 8'h55);
    t_fetch(16'h8001, 8'hAA);                 // expects refresh 0x80
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule